// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm Compare

A free-running 48-bit tick counter that advances once on every cycle where a 32.768 kHz tick enable is high, so bit 15 of the count is the least significant bit of whole seconds. Software sees the count as three 16-bit halfwords on a simple register bus and can overwrite any one of them. The block also holds a 48-bit alarm compare value.

When a tick moves the count onto the compare value, an alarm flag is latched in a status register. Software clears the flag by writing a one to it. An enable bit gates the flag onto the interrupt pin. Reads are combinational and have no side effects, so a reader that reads all three halfwords twice and retries on a mismatch always sees a counter that keeps running.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: After reset the count, the compare value, the alarm flag and the enable bit are all zero, and `irq_o` is low.
- R2: Each clock cycle with `tick_en_i` high and no count write increments the 48-bit count by one. The count wraps from all ones to zero.
- R3: The count halfwords read at byte offsets 0x00 (bits 15:0), 0x02 (bits 31:16) and 0x04 (bits 47:32). Reads do not disturb counting.
- R4: A write to one count halfword replaces only that halfword. No tick is applied in that cycle, and counting resumes from the new value. With no tick and no write, the count holds.
- R5: A carry from an increment propagates across halfword boundaries, from low into middle and from middle into high.
- R6: The compare value reads and writes at 0x08 (bits 15:0), 0x0A (bits 31:16) and 0x0C (bits 47:32).
- R7: Bit 0 of the status register at 0x1E sets only on a tick that makes the count equal to the compare value. It does not set while the two merely stay equal, on a count load, or on a compare write.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R9: If a match tick and a clearing write fall in the same cycle, the flag ends set.
- R10: Bit 0 at 0x10 is the alarm enable. `irq_o` equals flag AND enable and stays high until the flag is cleared or the enable is removed. The flag sets regardless of the enable.
- R11: Unmapped offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | 32.768 kHz count enable, one cycle per tick |
| addr_i | input | 5 | Byte offset of the halfword register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The alarm match and the software clear of the flag can land in the same cycle. A tick that turns the count into the compare value can also coincide with a write to a count or compare halfword. The bench sets the compare one tick ahead of the count and then issues a ticking step that also carries a clearing status write, or a count write. It expects the flag to be set in the first case and not set in the second. Random traffic then keeps placing the compare a few ticks ahead of the count while clears and writes land at random, and a bench model judges every read.

// File: rtl/eat_pkg.sv
package eat_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] CNT_BASE  = 5'h00;
  localparam logic [ADDR_W-1:0] CMP_BASE  = 5'h08;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 5'h10;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 5'h1E;
endpackage

// File: rtl/eat_counter.sv
module eat_counter #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned HW    = 16,
  localparam int unsigned NUM_HW = CNT_W / HW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_HW-1:0] hw_we_i,
  input  logic [HW-1:0]     wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q, inc;
  logic             any_we;

  assign inc    = cnt_q + CNT_W'(1);
  assign any_we = |hw_we_i;

  for (genvar g = 0; g < NUM_HW; g++) begin : g_hw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q[g*HW +: HW] <= '0;
      else if (hw_we_i[g])     cnt_q[g*HW +: HW] <= wdata_i;
      else if (tick_i && !any_we) cnt_q[g*HW +: HW] <= inc[g*HW +: HW];
    end
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !any_we |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !any_we |=> $stable(cnt_q));
endmodule

// File: rtl/eat_compare.sv
module eat_compare #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned HW    = 16,
  localparam int unsigned NUM_HW = CNT_W / HW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [NUM_HW-1:0] hw_we_i,
  input  logic [HW-1:0]     wdata_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              match_o
);
  logic [CNT_W-1:0] cmp_q;

  for (genvar g = 0; g < NUM_HW; g++) begin : g_hw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cmp_q[g*HW +: HW] <= '0;
      else if (hw_we_i[g]) cmp_q[g*HW +: HW] <= wdata_i;
    end
  end

  // fires only on the tick that lands on the compare value
  assign match_o = tick_i && !cnt_wr_i && ((cnt_i + CNT_W'(1)) == cmp_q);
  assign cmp_o   = cmp_q;
endmodule

// File: rtl/eat_irq.sv
module eat_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_wd_i,
  output logic flag_o,
  output logic en_o,
  output logic irq_o
);
  logic flag_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (set_i)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      if (en_we_i)    en_q   <= en_wd_i;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = flag_q & en_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R8
  w1c_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_q);
endmodule

// File: rtl/elapsed_alarm_timer.sv
module elapsed_alarm_timer
  import eat_pkg::*;
#(
  parameter int unsigned CNT_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int unsigned NUM_HW = CNT_W / BUS_W;

  logic [NUM_HW-1:0] cnt_we, cmp_we;
  logic [CNT_W-1:0]  cnt, cmp;
  logic              match, flag, en, clr, en_we;

  always_comb begin
    for (int i = 0; i < NUM_HW; i++) begin
      cnt_we[i] = we_i && (addr_i == ADDR_W'(CNT_BASE + 2*i));
      cmp_we[i] = we_i && (addr_i == ADDR_W'(CMP_BASE + 2*i));
    end
  end

  assign clr   = we_i && (addr_i == STAT_ADDR) && wdata_i[0];
  assign en_we = we_i && (addr_i == EN_ADDR);

  eat_counter #(.CNT_W(CNT_W), .HW(BUS_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick_en_i), .hw_we_i(cnt_we),
    .wdata_i, .cnt_o(cnt)
  );

  eat_compare #(.CNT_W(CNT_W), .HW(BUS_W)) u_cmp (
    .clk_i, .rst_ni, .tick_i(tick_en_i), .cnt_wr_i(|cnt_we), .cnt_i(cnt),
    .hw_we_i(cmp_we), .wdata_i, .cmp_o(cmp), .match_o(match)
  );

  eat_irq u_irq (
    .clk_i, .rst_ni, .set_i(match), .clr_i(clr), .en_we_i(en_we),
    .en_wd_i(wdata_i[0]), .flag_o(flag), .en_o(en), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_HW; i++) begin
      if (addr_i == ADDR_W'(CNT_BASE + 2*i)) rdata_o = cnt[i*BUS_W +: BUS_W];
      if (addr_i == ADDR_W'(CMP_BASE + 2*i)) rdata_o = cmp[i*BUS_W +: BUS_W];
    end
    if (addr_i == EN_ADDR)   rdata_o = {{(BUS_W-1){1'b0}}, en};
    if (addr_i == STAT_ADDR) rdata_o = {{(BUS_W-1){1'b0}}, flag};
  end

  // R7
  alarm_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> cnt == $past(cmp));
  // R7
  alarm_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(cnt) != $past(cmp));
endmodule

// File: tb/elapsed_alarm_timer_tb_top.sv
module elapsed_alarm_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [47:0] m_cnt = '0, m_cmp = '0;
  logic        m_flag = 1'b0, m_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elapsed_alarm_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] model_read(logic [4:0] a);
    case (a)
      5'h00: return m_cnt[15:0];
      5'h02: return m_cnt[31:16];
      5'h04: return m_cnt[47:32];
      5'h08: return m_cmp[15:0];
      5'h0A: return m_cmp[31:16];
      5'h0C: return m_cmp[47:32];
      5'h10: return {15'b0, m_en};
      5'h1E: return {15'b0, m_flag};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; model advances from pre-edge state
  task automatic step(bit t, bit w, logic [4:0] a, logic [15:0] d,
                      bit do_chk, string req);
    logic [47:0] n_cnt, n_cmp;
    logic        cw, n_flag, n_en, hit;
    @(negedge clk);
    tick = t; we = w; addr = a; wdata = d;
    #1;
    if (do_chk) begin
      if (!w) chk(req, {32'b0, rdata}, {32'b0, model_read(a)});
      chk({req, " irq"}, {47'b0, irq}, {47'b0, m_flag & m_en});
    end
    cw = w && (a == 5'h00 || a == 5'h02 || a == 5'h04);
    hit = t && !cw && (m_cnt + 48'd1 == m_cmp);
    n_cnt = m_cnt; n_cmp = m_cmp; n_flag = m_flag; n_en = m_en;
    if (w) case (a)
      5'h00: n_cnt[15:0]  = d;
      5'h02: n_cnt[31:16] = d;
      5'h04: n_cnt[47:32] = d;
      5'h08: n_cmp[15:0]  = d;
      5'h0A: n_cmp[31:16] = d;
      5'h0C: n_cmp[47:32] = d;
      5'h10: n_en = d[0];
      default: ;
    endcase
    if (t && !cw) n_cnt = m_cnt + 48'd1;
    if (hit) n_flag = 1'b1;
    else if (w && a == 5'h1E && d[0]) n_flag = 1'b0;
    @(posedge clk);
    m_cnt = n_cnt; m_cmp = n_cmp; m_flag = n_flag; m_en = n_en;
  endtask

  task automatic rd(logic [4:0] a, string req);
    step(1'b0, 1'b0, a, 16'h0, 1'b1, req);
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    step(1'b0, 1'b1, a, d, 1'b0, "");
  endtask

  task automatic load_cnt(logic [47:0] v);
    wr(5'h00, v[15:0]); wr(5'h02, v[31:16]); wr(5'h04, v[47:32]);
  endtask

  task automatic load_cmp(logic [47:0] v);
    wr(5'h08, v[15:0]); wr(5'h0A, v[31:16]); wr(5'h0C, v[47:32]);
  endtask

  task automatic rd_all(string req);
    foreach (model_read_addrs[i]) rd(model_read_addrs[i], req);
  endtask

  logic [4:0] model_read_addrs [8] = '{5'h00, 5'h02, 5'h04, 5'h08, 5'h0A,
                                       5'h0C, 5'h10, 5'h1E};

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 chk("R1 irq at reset", {47'b0, irq}, 48'b0);
    rst_n = 1'b1;
    rd_all("R1");

    // R2 / R3 counting observed while reading
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 5'h00, 16'h0, 1'b1, "R3 read while counting");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 5'h00, 16'h0, 1'b1, "R4 hold");

    // R5 carry chain and R2 wrap
    load_cnt(48'h0000_FFFF_FFFF);
    step(1'b1, 1'b0, 5'h00, 16'h0, 1'b0, "");
    rd(5'h00, "R5"); rd(5'h02, "R5"); rd(5'h04, "R5");
    load_cnt(ONES);
    step(1'b1, 1'b0, 5'h04, 16'h0, 1'b0, "");
    rd(5'h00, "R2 wrap"); rd(5'h04, "R2 wrap");

    // R4 single-halfword write beats a tick
    load_cnt(48'h1111_2222_3333);
    step(1'b1, 1'b1, 5'h02, 16'hABCD, 1'b0, "");
    rd(5'h00, "R4 other half"); rd(5'h02, "R4 replaced"); rd(5'h04, "R4 other half");
    step(1'b1, 1'b0, 5'h00, 16'h0, 1'b0, "");
    rd(5'h00, "R4 resume");

    // R6 compare access
    load_cmp(48'hDEAD_BEEF_0123);
    rd(5'h08, "R6"); rd(5'h0A, "R6"); rd(5'h0C, "R6");

    // R11 unmapped
    wr(5'h06, 16'hFFFF); wr(5'h12, 16'hFFFF); wr(5'h1C, 16'hFFFF);
    rd(5'h06, "R11"); rd(5'h1C, "R11"); rd_all("R11 no side effect");

    // R7 match on tick, R10 gating
    load_cnt(48'h0000_0000_0010);
    load_cmp(48'h0000_0000_0013);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 5'h1E, 16'h0, 1'b1, "R7 approach");
    rd(5'h1E, "R7 flag set");
    rd(5'h1E, "R10 irq masked");
    wr(5'h10, 16'h0001);
    rd(5'h10, "R10 enable reads");
    rd(5'h1E, "R10 irq asserted");
    // R8 write 0 no effect, write 1 clears
    wr(5'h1E, 16'hFFFE); rd(5'h1E, "R8 zero write");
    wr(5'h1E, 16'h0001); rd(5'h1E, "R8 cleared");
    // R7 stays equal: no retrigger
    for (int i = 0; i < 4; i++) rd(5'h1E, "R7 no retrigger");
    // R7 load onto compare, compare onto count: no set
    load_cnt(48'h0000_0000_0050);
    load_cmp(48'h0000_0000_0050);
    rd(5'h1E, "R7 no set on writes");
    // R9 collision: match and clear same cycle
    load_cmp(48'h0000_0000_0051);
    step(1'b1, 1'b1, 5'h1E, 16'h0001, 1'b0, "");
    rd(5'h1E, "R9 set wins");
    wr(5'h1E, 16'h0001);
    // R7 count write on matching tick blocks set
    load_cmp(48'h0000_0000_0052);
    step(1'b1, 1'b1, 5'h04, 16'h0000, 1'b0, "");
    rd(5'h1E, "R7 write blocks match");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom % 100;
      logic [4:0] a = model_read_addrs[$urandom % 8];
      bit t = ($urandom % 4) != 0;
      if (r < 8) begin
        logic [47:0] c = m_cnt + 48'($urandom % 6 + 1);
        int unsigned k = $urandom % 3;
        step(t, 1'b1, 5'(5'h08 + 2*k), c[k*16 +: 16], 1'b0, "");
      end else if (r < 14) step(t, 1'b1, 5'h1E, 16'($urandom), 1'b0, "");
      else if (r < 16) step(t, 1'b1, 5'h10, 16'($urandom), 1'b0, "");
      else if (r < 18) step(t, 1'b1, 5'h00, 16'($urandom), 1'b0, "");
      else step(t, 1'b0, a, 16'h0, 1'b1, "R7 random");
    end
    rd_all("R3 random end");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule